// File: doc/BRIEF.md
# Receive Signaling Integrator and Freeze

This block conditions the received four-bit (ABCD) robbed-bit signaling of each channel before it leaves on the receive signaling output and on the reinserted serial output. One channel is presented per cycle: a channel number, that channel's signaling nibble, and a strobe that marks the sample taken at a multiframe boundary. Each channel owns a small state record: its reported nibble, a candidate nibble and a stability count. All channel records sit in one register store.

With debounce off, the reported value follows the input at once. With debounce on, a new value must be seen unchanged at three multiframe boundaries before it replaces the reported value. A freeze, caused by an external event such as loss of frame when freezing is enabled, or caused at any time by the force-freeze control, holds the reported value and restarts the debounce. A force-ones control, qualified by a per-channel mask, drives the serial-side nibble to all ones.

The result for a processed channel appears one cycle later, together with a valid flag and the channel number.

Top module: `rx_sig_conditioner`

## Requirements
- R1: After reset, every channel's reported nibble is 0000 and `out_valid_o` is low.
- R2: With `integ_en` low and no freeze, the nibble reported for a channel equals the `sig_in` presented with it. It appears on `rsig_o` the next cycle.
- R3: With `integ_en` high, a new value replaces the reported value only on the third `mf_strobe` sample of that channel that equals the candidate. The candidate is set by the first differing sample. The stability count never reaches 3.
- R4: With `integ_en` high, a sample that differs from the candidate makes it the new candidate and clears the count, so a one-sample glitch restarts the three-boundary wait.
- R5: Samples taken with `mf_strobe` low never advance the count and never change the reported value while `integ_en` is high.
- R6: When `freeze_en` and `freeze_evt` are both high, the reported nibble of the processed channel is held. This applies to both `rsig_o` and `rser_o`.
- R7: `force_freeze` high holds the reported nibble even when `freeze_en` is low.
- R8: With `freeze_en` and `force_freeze` both low, `freeze_evt` has no effect.
- R9: Any sample taken during a freeze clears the channel's count, so after release a change needs three fresh boundary samples.
- R10: When `force_ones` is high and bit n of `ones_mask` is set, `rser_o` for channel n is 1111. `rsig_o` still carries the reported nibble.
- R11: When `force_ones` is low, or the channel's mask bit is clear, `rser_o` equals `rsig_o`.
- R12: A channel number of NCH or above is ignored. The next cycle `out_valid_o` is low and no channel state changes.
- R13: For a valid channel, `out_valid_o` is high one cycle after `ch_valid` and `out_idx_o` carries the channel number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid | input | 1 | A channel sample is presented |
| ch_idx | input | 5 | Channel number (0..NCH-1) |
| sig_in | input | 4 | Received signaling nibble of the channel |
| mf_strobe | input | 1 | Sample is at a multiframe boundary |
| freeze_evt | input | 1 | External freeze condition (e.g. loss of frame) |
| integ_en | input | 1 | Enable three-multiframe debounce |
| freeze_en | input | 1 | Allow freeze_evt to freeze |
| force_freeze | input | 1 | Freeze regardless of freeze_en |
| force_ones | input | 1 | Enable all-ones forcing on the serial side |
| ones_mask | input | 24 | Per-channel all-ones select |
| out_valid_o | output | 1 | Output nibbles are valid |
| out_idx_o | output | 5 | Channel the outputs belong to |
| rsig_o | output | 4 | Reported signaling nibble |
| rser_o | output | 4 | Serial-side nibble after forcing |

## Verification
Debounce is tried with a clean change held across boundaries, with non-boundary samples mixed in, and with a one-sample glitch inside the wait. Together these separate a correct count from one that counts every sample or one that ignores mismatches. Freeze is driven through the enable path, the force path and the event alone. A freeze is also placed in the middle of a debounce wait, which shows whether counts restart. A long pseudo-random stream over all channels and controls, plus out-of-range channel numbers, is compared against a behavioural model every cycle. A final sweep reads back every channel.

// File: rtl/rsi_pkg.sv
package rsi_pkg;
    localparam int SIG_W    = 4;
    localparam int INTEG_MF = 3;
    localparam int CNT_W    = $clog2(INTEG_MF);

    typedef struct packed {
        logic [SIG_W-1:0] rep;
        logic [SIG_W-1:0] cand;
        logic [CNT_W-1:0] cnt;
    } chan_t;
endpackage

// File: rtl/rsi_chan_update.sv
module rsi_chan_update
    import rsi_pkg::*;
(
    input  chan_t            cur,
    input  logic [SIG_W-1:0] sig,
    input  logic             mf,
    input  logic             frozen,
    input  logic             integ_en,
    output chan_t            nxt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTEG_MF - 1);

    always_comb begin
        nxt = cur;
        if (frozen) begin
            // hold the report, restart debounce
            nxt.cand = sig;
            nxt.cnt  = '0;
        end else if (!integ_en) begin
            nxt.rep  = sig;
            nxt.cand = sig;
            nxt.cnt  = '0;
        end else if (sig != cur.cand) begin
            nxt.cand = sig;
            nxt.cnt  = '0;
        end else if (sig == cur.rep) begin
            nxt.cnt  = '0;
        end else if (mf) begin
            if (cur.cnt == LAST) begin
                nxt.rep = cur.cand;
                nxt.cnt = '0;
            end else begin
                nxt.cnt = cur.cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rsi_ones_mux.sv
module rsi_ones_mux
    import rsi_pkg::*;
(
    input  logic [SIG_W-1:0] rep,
    input  logic             force_ones,
    input  logic             mask_bit,
    output logic [SIG_W-1:0] ser
);
    always_comb begin
        ser = (force_ones && mask_bit) ? {SIG_W{1'b1}} : rep;
    end
endmodule

// File: rtl/rx_sig_conditioner.sv
module rx_sig_conditioner
    import rsi_pkg::*;
#(
    parameter int NCH  = 24,
    parameter int IDXW = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_valid,
    input  logic [IDXW-1:0]  ch_idx,
    input  logic [SIG_W-1:0] sig_in,
    input  logic             mf_strobe,
    input  logic             freeze_evt,
    input  logic             integ_en,
    input  logic             freeze_en,
    input  logic             force_freeze,
    input  logic             force_ones,
    input  logic [NCH-1:0]   ones_mask,
    output logic             out_valid_o,
    output logic [IDXW-1:0]  out_idx_o,
    output logic [SIG_W-1:0] rsig_o,
    output logic [SIG_W-1:0] rser_o
);
    typedef struct packed {
        chan_t [NCH-1:0]  mem;
        logic             vld;
        logic [IDXW-1:0]  idx;
        logic [SIG_W-1:0] rsig;
        logic [SIG_W-1:0] rser;
    } regs_t;

    regs_t            q, d;
    chan_t            cur_d, upd_d;
    logic             in_range, frozen, mask_bit;
    logic [SIG_W-1:0] ser_d;

    always_comb begin
        in_range = ch_valid && ({1'b0, ch_idx} < (IDXW+1)'(NCH));
        frozen   = force_freeze || (freeze_en && freeze_evt);
        cur_d    = q.mem[ch_idx];
        mask_bit = ones_mask[ch_idx];
    end

    rsi_chan_update u_upd (
        .cur      (cur_d),
        .sig      (sig_in),
        .mf       (mf_strobe),
        .frozen   (frozen),
        .integ_en (integ_en),
        .nxt      (upd_d)
    );

    rsi_ones_mux u_mux (
        .rep        (upd_d.rep),
        .force_ones (force_ones),
        .mask_bit   (mask_bit),
        .ser        (ser_d)
    );

    always_comb begin
        d     = q;
        d.vld = in_range;
        if (in_range) begin
            d.mem[ch_idx] = upd_d;
            d.idx         = ch_idx;
            d.rsig        = upd_d.rep;
            d.rser        = ser_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid_o = q.vld;
    assign out_idx_o   = q.idx;
    assign rsig_o      = q.rsig;
    assign rser_o      = q.rser;

    a_r13_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> ({1'b0, out_idx_o} < (IDXW+1)'(NCH)));

    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (int'(q.mem[out_idx_o].cnt) < INTEG_MF));

    a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (in_range && !frozen && !integ_en) |=> (rsig_o == $past(sig_in)));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_range && frozen) |=> (rsig_o == $past(q.mem[ch_idx].rep)));

    a_r10_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (in_range && force_ones && ones_mask[ch_idx]) |=> (rser_o == {SIG_W{1'b1}}));

    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_range && !force_ones) |=> (rser_o == rsig_o));

    a_r12_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_range) |=> !out_valid_o);
endmodule

// File: tb/sim_rx_sig_conditioner.sv
module sim_rx_sig_conditioner;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ch_valid = 1'b0;
    logic [4:0]  ch_idx = '0;
    logic [3:0]  sig_in = '0;
    logic        mf_strobe = 1'b0;
    logic        freeze_evt = 1'b0;
    logic        integ_en = 1'b0;
    logic        freeze_en = 1'b0;
    logic        force_freeze = 1'b0;
    logic        force_ones = 1'b0;
    logic [23:0] ones_mask = '0;
    logic        out_valid_o;
    logic [4:0]  out_idx_o;
    logic [3:0]  rsig_o, rser_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    int m_rep[NCH];
    int m_cand[NCH];
    int m_seen[NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_sig_conditioner u0 (
        .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_idx(ch_idx),
        .sig_in(sig_in), .mf_strobe(mf_strobe), .freeze_evt(freeze_evt),
        .integ_en(integ_en), .freeze_en(freeze_en), .force_freeze(force_freeze),
        .force_ones(force_ones), .ones_mask(ones_mask),
        .out_valid_o(out_valid_o), .out_idx_o(out_idx_o),
        .rsig_o(rsig_o), .rser_o(rser_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, compare at the following negedge
    task automatic step(input int idx, input int sig, input bit mf, input string tag);
        bit hold, vexp;
        int rexp, sexp;
        ch_valid = 1'b1; ch_idx = 5'(idx); sig_in = 4'(sig); mf_strobe = mf;
        hold = force_freeze || (freeze_en && freeze_evt);
        vexp = (idx < NCH);
        rexp = 0; sexp = 0;
        if (vexp) begin
            if (hold) begin
                m_cand[idx] = sig; m_seen[idx] = 0;
            end else if (!integ_en) begin
                m_rep[idx] = sig; m_cand[idx] = sig; m_seen[idx] = 0;
            end else if (sig != m_cand[idx]) begin
                m_cand[idx] = sig; m_seen[idx] = 0;
            end else if (sig == m_rep[idx]) begin
                m_seen[idx] = 0;
            end else if (mf) begin
                m_seen[idx] += 1;
                if (m_seen[idx] == 3) begin
                    m_rep[idx] = sig; m_seen[idx] = 0;
                end
            end
            rexp = m_rep[idx];
            sexp = (force_ones && ones_mask[idx]) ? 15 : rexp;
        end
        @(negedge clk);
        if (!vexp) chk("R12 valid", out_valid_o, 0);
        else begin
            chk("R13 valid", out_valid_o, 1);
            chk("R13 idx", out_idx_o, idx);
            chk({tag, " rsig"}, rsig_o, rexp);
            chk((force_ones && ones_mask[idx]) ? "R10 rser" : "R11 rser", rser_o, sexp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        for (int i = 0; i < NCH; i++) begin m_rep[i] = 0; m_cand[i] = 0; m_seen[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 valid", out_valid_o, 0);
        chk("R1 rsig", rsig_o, 0);
        integ_en = 1'b1;
        for (int i = 0; i < NCH; i++) step(i, 0, 1'b0, "R1");

        // R2 immediate report
        integ_en = 1'b0;
        step(3, 5, 1'b0, "R2");
        step(7, 10, 1'b0, "R2");
        step(7, 2, 1'b1, "R2");

        // R3 / R5 debounce with non-boundary samples between
        integ_en = 1'b1;
        step(5, 9, 1'b1, "R3");
        step(5, 9, 1'b0, "R5");
        step(5, 9, 1'b1, "R3");
        step(5, 9, 1'b0, "R5");
        step(5, 9, 1'b0, "R5");
        step(5, 9, 1'b1, "R3");
        step(5, 9, 1'b0, "R5");
        step(5, 9, 1'b1, "R3");

        // R4 glitch restarts the wait
        step(6, 3, 1'b1, "R4");
        step(6, 3, 1'b1, "R4");
        step(6, 3, 1'b1, "R4");
        step(6, 4, 1'b1, "R4");
        step(6, 3, 1'b1, "R4");
        step(6, 3, 1'b1, "R4");
        step(6, 3, 1'b1, "R4");
        step(6, 3, 1'b1, "R4");

        // R6 / R8 / R7 freeze paths
        integ_en = 1'b0;
        freeze_en = 1'b1; freeze_evt = 1'b1;
        step(3, 12, 1'b0, "R6");
        freeze_en = 1'b0;
        step(3, 12, 1'b0, "R8");
        force_freeze = 1'b1;
        step(3, 1, 1'b0, "R7");
        force_freeze = 1'b0; freeze_evt = 1'b0;

        // R9 freeze mid-wait
        integ_en = 1'b1;
        step(8, 14, 1'b1, "R9");
        step(8, 14, 1'b1, "R9");
        step(8, 14, 1'b1, "R9");
        force_freeze = 1'b1;
        step(8, 14, 1'b1, "R9");
        force_freeze = 1'b0;
        step(8, 14, 1'b1, "R9");
        step(8, 14, 1'b1, "R9");
        step(8, 14, 1'b1, "R9");

        // R10 / R11 forcing
        ones_mask = 24'h000008;
        force_ones = 1'b1;
        step(3, 12, 1'b0, "R10");
        step(4, 0, 1'b0, "R11");
        force_ones = 1'b0;
        step(3, 12, 1'b0, "R11");

        // R12 out-of-range channel
        integ_en = 1'b0;
        step(25, 15, 1'b1, "R12");
        step(24, 15, 1'b1, "R12");

        // mixed stream
        seed = 32'h1234_5678;
        for (int n = 0; n < 600; n++) begin
            int r;
            seed = seed * 1103515245 + 12345;
            r = seed >>> 8;
            integ_en     = (r[3:0] != 0);
            freeze_en    = r[4];
            freeze_evt   = r[5] & r[6];
            force_freeze = (r[10:7] == 0);
            force_ones   = r[11];
            ones_mask    = {r[23:12], r[23:12]};
            step((r[28:24] < 26) ? int'(r[28:24]) : int'(r[26:24]),
                 r[13] ? int'(r[17:14]) : m_cand[r[26:24]], r[18], "R3");
        end

        // sweep readback
        integ_en = 1'b1; freeze_en = 1'b0; force_freeze = 1'b0; force_ones = 1'b0;
        for (int i = 0; i < NCH; i++) step(i, 0, 1'b0, "R12");
        ch_valid = 1'b0;
        @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule